// File: doc/BRIEF.md
# Double-Banked Polyphase Scaler Coefficient Store

This block holds the filter coefficients that a polyphase image scaler applies to each output sample. Six tables are kept: vertical and horizontal filters for luma, chroma and alpha. Because the filter is symmetric, only the first half of the phase range plus the centre phase is stored. Each entry is a tap pair that carries an even-tap and an odd-tap coefficient. Two complete banks exist. The filter datapath reads from the active bank while a host reloads the other one.

The host loads a start address made of filter type, phase and tap pair. It then streams data words. Each word carries both coefficients, and each half has its own enable. The write pointer steps by itself after every data word: it runs through the tap pairs implied by the configured tap count, then moves to the next phase. A mode write requests a bank select and a chroma-table mode. Both take effect only on a frame-start strobe, so the datapath never sees a table that is half loaded.

The read port takes a filter type, phase and tap pair. One cycle later it returns both coefficients of that pair from the active bank.

Top module: `scl_coef_store`

## Requirements
- R1: Filter type codes are luma vertical 0, luma horizontal 1, chroma vertical 2, chroma horizontal 3, alpha vertical 4, alpha horizontal 5. Phases 0 to 32 are stored. A data write addressed to type 6 or 7, or to a phase above 32, is dropped. A read of such an address returns zero in both halves.
- R2: A data word writes its even coefficient only when dat_even_en is 1, and its odd coefficient only when dat_odd_en is 1. A disabled half keeps its old value.
- R3: The two least significant bits of every stored coefficient read back as zero, whatever was written.
- R4: After each data write the pointer advances the tap pair first. The pair count is (taps+1)/2, with taps clamped to 1..8. After the last pair the pointer returns to pair 0 of the next phase, and after phase 32 it returns to phase 0. Loading a start address takes priority over the increment.
- R5: When the configured tap count is odd, the odd coefficient of the last tap pair is stored as zero.
- R6: Data writes always land in the bank that is not currently active. Reads always come from the active bank.
- R7: A mode write records a requested bank select and chroma mode. At the next frame_start the requests become active. cur_bank reports the active bank, so writing the inverse of cur_bank followed by a frame_start swaps the banks. cur_bank changes at no other time.
- R8: With chroma mode active, chroma reads use the chroma tables. With it clear, a read of type 2 or 3 returns luma type 0 or 1 respectively. A change of chroma mode takes effect only at frame_start.
- R9: rd_valid is high exactly in the cycle after a cycle with rd_en high. rd_even and rd_odd then hold the addressed pair.
- R10: After reset, cur_bank and chroma_active are 0, rd_valid is 0 and the write pointer is at type 0, phase 0, pair 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_taps | input | 4 | Tap count that drives the pointer increment (1..8) |
| addr_we | input | 1 | Load the write pointer from the addr_* fields |
| addr_type | input | 3 | Start filter type |
| addr_phase | input | 6 | Start phase |
| addr_pair | input | 2 | Start tap pair |
| dat_we | input | 1 | Data word strobe |
| dat_even | input | 14 | Even-tap coefficient |
| dat_even_en | input | 1 | Write enable for the even half |
| dat_odd | input | 14 | Odd-tap coefficient |
| dat_odd_en | input | 1 | Write enable for the odd half |
| mode_we | input | 1 | Record a requested bank select and chroma mode |
| mode_bank | input | 1 | Requested active bank |
| mode_chroma | input | 1 | Requested chroma-table mode |
| frame_start | input | 1 | Frame-start strobe that applies pending requests |
| cur_bank | output | 1 | Active bank |
| chroma_active | output | 1 | Active chroma-table mode |
| rd_en | input | 1 | Read request |
| rd_type | input | 3 | Read filter type |
| rd_phase | input | 6 | Read phase |
| rd_pair | input | 2 | Read tap pair |
| rd_valid | output | 1 | Read data valid |
| rd_even | output | 14 | Even coefficient read back |
| rd_odd | output | 14 | Odd coefficient read back |

## Verification
The bench fills the hidden bank and checks that reads still return the old bank until frame_start, and that cur_bank does not move on the mode write alone. A design that swapped early would return partial tables. It loads a three-tap table, where a pointer that ignored the tap count would skew every following phase and a missing odd-zero rule would leave a stray coefficient. It also wraps the pointer from phase 32 back to phase 0. Half-enable writes, low-bit masking, out-of-range types and phases, and luma aliasing of chroma reads before and after the chroma mode is applied are each compared against a reference model of both banks kept by the bench.

// File: rtl/coef_pkg.sv
package coef_pkg;
   localparam int TYPE_W       = 3;
   localparam int N_FILT_TYPES = 6;

   localparam logic [TYPE_W-1:0] FT_LUMA_V   = 3'd0;
   localparam logic [TYPE_W-1:0] FT_LUMA_H   = 3'd1;
   localparam logic [TYPE_W-1:0] FT_CHROMA_V = 3'd2;
   localparam logic [TYPE_W-1:0] FT_CHROMA_H = 3'd3;
   localparam logic [TYPE_W-1:0] FT_ALPHA_V  = 3'd4;
   localparam logic [TYPE_W-1:0] FT_ALPHA_H  = 3'd5;

   typedef struct packed {
      logic       bank;
      logic       chroma;
   } coef_mode_t;
endpackage

// File: rtl/coef_wr_seq.sv
module coef_wr_seq
   import coef_pkg::*;
#(
   parameter int MAX_TAPS = 8,
   parameter int N_PHASE  = 33,
   parameter int TAPS_W   = 4,
   parameter int PHASE_W  = 6,
   parameter int PAIR_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TAPS_W-1:0]  taps,
   input  logic               addr_we,
   input  logic [TYPE_W-1:0]  addr_type,
   input  logic [PHASE_W-1:0] addr_phase,
   input  logic [PAIR_W-1:0]  addr_pair,
   input  logic               dat_we,
   output logic [TYPE_W-1:0]  wr_type,
   output logic [PHASE_W-1:0] wr_phase,
   output logic [PAIR_W-1:0]  wr_pair,
   output logic               wr_odd_zero
);
   localparam logic [TAPS_W:0]  TAPS_MAX_V = (TAPS_W+1)'(MAX_TAPS);
   localparam logic [PHASE_W-1:0] PH_LAST  = PHASE_W'(N_PHASE - 1);

   logic [TYPE_W-1:0]  type_q;
   logic [PHASE_W-1:0] phase_q;
   logic [PAIR_W-1:0]  pair_q;
   logic [TAPS_W:0]    taps_eff;
   logic [TAPS_W:0]    pair_cnt;
   logic [PAIR_W-1:0]  last_pair;
   logic               at_last;

   always_comb begin
      if (taps == '0)
         taps_eff = (TAPS_W+1)'(1);
      else if ({1'b0, taps} > TAPS_MAX_V)
         taps_eff = TAPS_MAX_V;
      else
         taps_eff = {1'b0, taps};
      pair_cnt  = (taps_eff + (TAPS_W+1)'(1)) >> 1;
      last_pair = PAIR_W'(pair_cnt - (TAPS_W+1)'(1));
      at_last   = (pair_q >= last_pair);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         type_q  <= '0;
         phase_q <= '0;
         pair_q  <= '0;
      end else if (addr_we) begin
         type_q  <= addr_type;
         phase_q <= addr_phase;
         pair_q  <= addr_pair;
      end else if (dat_we) begin
         if (at_last) begin
            pair_q  <= '0;
            phase_q <= (phase_q >= PH_LAST) ? '0 : phase_q + PHASE_W'(1);
         end else begin
            pair_q  <= pair_q + PAIR_W'(1);
         end
      end
   end

   assign wr_type     = type_q;
   assign wr_phase    = phase_q;
   assign wr_pair     = pair_q;
   assign wr_odd_zero = taps_eff[0] && (pair_q == last_pair);

   // R4
   pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && !addr_we && !at_last) |=>
         (pair_q == $past(pair_q) + PAIR_W'(1)) && $stable(phase_q));

   // R4
   phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && !addr_we && at_last && phase_q < PH_LAST) |=>
         (pair_q == '0) && (phase_q == $past(phase_q) + PHASE_W'(1)));

   // R4
   phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && !addr_we && at_last && phase_q >= PH_LAST) |=>
         (pair_q == '0) && (phase_q == '0));
endmodule

// File: rtl/coef_bank_ctl.sv
module coef_bank_ctl
   import coef_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic mode_we,
   input  logic mode_bank,
   input  logic mode_chroma,
   input  logic frame_start,
   output logic cur_bank,
   output logic chroma_on
);
   coef_mode_t pend_q;
   coef_mode_t act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         if (mode_we) begin
            pend_q.bank   <= mode_bank;
            pend_q.chroma <= mode_chroma;
         end
         if (frame_start)
            act_q <= pend_q;
      end
   end

   assign cur_bank  = act_q.bank;
   assign chroma_on = act_q.chroma;

   // R7
   bank_moves_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_bank) |-> $past(frame_start));

   // R8
   chroma_moves_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(chroma_on) |-> $past(frame_start));

   // R7
   bank_follows_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !mode_we) |=> (cur_bank == $past(pend_q.bank)));
endmodule

// File: rtl/coef_bank_mem.sv
module coef_bank_mem #(
   parameter int COEF_W = 14,
   parameter int DEPTH  = 792,
   parameter int IDX_W  = 10
) (
   input  logic              clk,
   input  logic              we_even,
   input  logic              we_odd,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [COEF_W-1:0] wr_even,
   input  logic [COEF_W-1:0] wr_odd,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [COEF_W-1:0] rd_even,
   output logic [COEF_W-1:0] rd_odd
);
   logic [COEF_W-1:0] mem_even [DEPTH];
   logic [COEF_W-1:0] mem_odd  [DEPTH];

   always_ff @(posedge clk) begin
      if (we_even)
         mem_even[wr_idx] <= wr_even;
      if (we_odd)
         mem_odd[wr_idx]  <= wr_odd;
   end

   assign rd_even = mem_even[rd_idx];
   assign rd_odd  = mem_odd[rd_idx];
endmodule

// File: rtl/scl_coef_store.sv
module scl_coef_store
   import coef_pkg::*;
#(
   parameter int COEF_W    = 14,
   parameter int ZERO_LSBS = 2,
   parameter int MAX_TAPS  = 8,
   parameter int N_PHASE   = 33,
   parameter int TAPS_W    = 4,
   parameter int PHASE_W   = 6,
   parameter int PAIR_W    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TAPS_W-1:0]  cfg_taps,
   input  logic               addr_we,
   input  logic [2:0]         addr_type,
   input  logic [PHASE_W-1:0] addr_phase,
   input  logic [PAIR_W-1:0]  addr_pair,
   input  logic               dat_we,
   input  logic [COEF_W-1:0]  dat_even,
   input  logic               dat_even_en,
   input  logic [COEF_W-1:0]  dat_odd,
   input  logic               dat_odd_en,
   input  logic               mode_we,
   input  logic               mode_bank,
   input  logic               mode_chroma,
   input  logic               frame_start,
   output logic               cur_bank,
   output logic               chroma_active,
   input  logic               rd_en,
   input  logic [2:0]         rd_type,
   input  logic [PHASE_W-1:0] rd_phase,
   input  logic [PAIR_W-1:0]  rd_pair,
   output logic               rd_valid,
   output logic [COEF_W-1:0]  rd_even,
   output logic [COEF_W-1:0]  rd_odd
);
   localparam int N_PAIRS = (MAX_TAPS + 1) / 2;
   localparam int DEPTH   = N_FILT_TYPES * N_PHASE * N_PAIRS;
   localparam int IDX_W   = $clog2(DEPTH);
   localparam int N_BANKS = 2;

   if (COEF_W <= ZERO_LSBS) begin : g_bad_coef_w
      $error("COEF_W must exceed ZERO_LSBS");
   end
   if (N_PAIRS > (1 << PAIR_W)) begin : g_bad_pair_w
      $error("PAIR_W too narrow for MAX_TAPS");
   end
   if (N_PHASE > (1 << PHASE_W)) begin : g_bad_phase_w
      $error("PHASE_W too narrow for N_PHASE");
   end
   if (MAX_TAPS >= (1 << TAPS_W)) begin : g_bad_taps_w
      $error("TAPS_W too narrow for MAX_TAPS");
   end

   function automatic logic [IDX_W-1:0] flat_idx(input logic [2:0] ft,
                                                 input logic [PHASE_W-1:0] ph,
                                                 input logic [PAIR_W-1:0] pr);
      int unsigned v;
      v = (int'(ft) * N_PHASE + int'(ph)) * N_PAIRS + int'(pr);
      return IDX_W'(v);
   endfunction

   // write pointer
   logic [2:0]         wp_type;
   logic [PHASE_W-1:0] wp_phase;
   logic [PAIR_W-1:0]  wp_pair;
   logic               wp_odd_zero;

   coef_wr_seq #(
      .MAX_TAPS (MAX_TAPS),
      .N_PHASE  (N_PHASE),
      .TAPS_W   (TAPS_W),
      .PHASE_W  (PHASE_W),
      .PAIR_W   (PAIR_W)
   ) u_wr_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .taps        (cfg_taps),
      .addr_we     (addr_we),
      .addr_type   (addr_type),
      .addr_phase  (addr_phase),
      .addr_pair   (addr_pair),
      .dat_we      (dat_we),
      .wr_type     (wp_type),
      .wr_phase    (wp_phase),
      .wr_pair     (wp_pair),
      .wr_odd_zero (wp_odd_zero)
   );

   // bank and chroma mode control
   coef_bank_ctl u_bank_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_we     (mode_we),
      .mode_bank   (mode_bank),
      .mode_chroma (mode_chroma),
      .frame_start (frame_start),
      .cur_bank    (cur_bank),
      .chroma_on   (chroma_active)
   );

   // write data shaping
   logic [COEF_W-1:0] even_m;
   logic [COEF_W-1:0] odd_m;
   logic [COEF_W-1:0] odd_final;

   if (ZERO_LSBS > 0) begin : g_lsb_mask
      assign even_m = {dat_even[COEF_W-1:ZERO_LSBS], {ZERO_LSBS{1'b0}}};
      assign odd_m  = {dat_odd[COEF_W-1:ZERO_LSBS],  {ZERO_LSBS{1'b0}}};
   end else begin : g_lsb_keep
      assign even_m = dat_even;
      assign odd_m  = dat_odd;
   end

   assign odd_final = wp_odd_zero ? '0 : odd_m;

   logic             wr_ok;
   logic [IDX_W-1:0] wr_idx;
   logic             wr_bank;

   assign wr_ok   = (wp_type < 3'(N_FILT_TYPES)) && (int'(wp_phase) < N_PHASE);
   assign wr_idx  = wr_ok ? flat_idx(wp_type, wp_phase, wp_pair) : '0;
   assign wr_bank = ~cur_bank;

   // read address with chroma aliasing
   logic [2:0]       rd_type_eff;
   logic             rd_ok;
   logic [IDX_W-1:0] rd_idx;

   always_comb begin
      if (!chroma_active && (rd_type == FT_CHROMA_V || rd_type == FT_CHROMA_H))
         rd_type_eff = rd_type - 3'd2;
      else
         rd_type_eff = rd_type;
   end

   assign rd_ok  = (rd_type < 3'(N_FILT_TYPES)) && (int'(rd_phase) < N_PHASE);
   assign rd_idx = rd_ok ? flat_idx(rd_type_eff, rd_phase, rd_pair) : '0;

   // banks
   logic [COEF_W-1:0] bank_even [N_BANKS];
   logic [COEF_W-1:0] bank_odd  [N_BANKS];

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = (wr_bank == 1'(b)) && wr_ok && dat_we;

      coef_bank_mem #(
         .COEF_W (COEF_W),
         .DEPTH  (DEPTH),
         .IDX_W  (IDX_W)
      ) u_mem (
         .clk     (clk),
         .we_even (sel && dat_even_en),
         .we_odd  (sel && dat_odd_en),
         .wr_idx  (wr_idx),
         .wr_even (even_m),
         .wr_odd  (odd_final),
         .rd_idx  (rd_idx),
         .rd_even (bank_even[b]),
         .rd_odd  (bank_odd[b])
      );
   end

   // registered read port
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_even  <= '0;
         rd_odd   <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_even <= rd_ok ? bank_even[cur_bank] : '0;
            rd_odd  <= rd_ok ? bank_odd[cur_bank]  : '0;
         end
      end
   end

   // R9
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // R9
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R1
   bad_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_ok) |=> (rd_even == '0) && (rd_odd == '0));

   // R6
   rd_stable_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en) && $stable(rd_type) && $stable(rd_phase) &&
       $stable(rd_pair) && $stable(cur_bank) && $stable(chroma_active) &&
       !$past(dat_we)) |=> $stable(rd_even) && $stable(rd_odd));

   if (ZERO_LSBS > 0) begin : g_lsb_chk
      // R3
      lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_valid |-> (rd_even[ZERO_LSBS-1:0] == '0) && (rd_odd[ZERO_LSBS-1:0] == '0));
   end
endmodule

// File: tb/scl_coef_store_tb.sv
`timescale 1ns/1ps
module scl_coef_store_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_taps = 4'd4;
   logic        addr_we = 0;
   logic [2:0]  addr_type = 0;
   logic [5:0]  addr_phase = 0;
   logic [1:0]  addr_pair = 0;
   logic        dat_we = 0;
   logic [13:0] dat_even = 0;
   logic        dat_even_en = 0;
   logic [13:0] dat_odd = 0;
   logic        dat_odd_en = 0;
   logic        mode_we = 0;
   logic        mode_bank = 0;
   logic        mode_chroma = 0;
   logic        frame_start = 0;
   logic        cur_bank;
   logic        chroma_active;
   logic        rd_en = 0;
   logic [2:0]  rd_type = 0;
   logic [5:0]  rd_phase = 0;
   logic [1:0]  rd_pair = 0;
   logic        rd_valid;
   logic [13:0] rd_even;
   logic [13:0] rd_odd;

   always #4 clk = ~clk;

   scl_coef_store u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_taps(cfg_taps),
      .addr_we(addr_we), .addr_type(addr_type), .addr_phase(addr_phase), .addr_pair(addr_pair),
      .dat_we(dat_we), .dat_even(dat_even), .dat_even_en(dat_even_en),
      .dat_odd(dat_odd), .dat_odd_en(dat_odd_en),
      .mode_we(mode_we), .mode_bank(mode_bank), .mode_chroma(mode_chroma),
      .frame_start(frame_start), .cur_bank(cur_bank), .chroma_active(chroma_active),
      .rd_en(rd_en), .rd_type(rd_type), .rd_phase(rd_phase), .rd_pair(rd_pair),
      .rd_valid(rd_valid), .rd_even(rd_even), .rd_odd(rd_odd)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference model of both banks
   int me [2][6][33][4];
   int mo [2][6][33][4];
   int m_act = 0, m_pend = 0, m_chr = 0, m_pchr = 0;
   int p_t = 0, p_p = 0, p_q = 0, m_taps = 4;

   int q_e[$];
   int q_o[$];
   string q_tag[$];

   function automatic int msk(int v);
      return v & 'h3FFC;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_taps(int n);
      @(negedge clk);
      cfg_taps = 4'(n);
      m_taps = n;
   endtask

   task automatic set_addr(int t, int p, int q);
      @(negedge clk);
      addr_we = 1; addr_type = 3'(t); addr_phase = 6'(p); addr_pair = 2'(q);
      p_t = t; p_p = p; p_q = q;
      @(negedge clk);
      addr_we = 0;
   endtask

   task automatic wr(int e, int o, bit ee, bit eo);
      int np, bk;
      bit oz;
      @(negedge clk);
      dat_we = 1; dat_even = 14'(e); dat_odd = 14'(o);
      dat_even_en = ee; dat_odd_en = eo;
      np = (m_taps + 1) / 2;
      oz = (m_taps % 2 == 1) && (p_q == np - 1);
      bk = 1 - m_act;
      if (p_t < 6 && p_p < 33) begin
         if (ee) me[bk][p_t][p_p][p_q] = msk(e);
         if (eo) mo[bk][p_t][p_p][p_q] = oz ? 0 : msk(o);
      end
      if (p_q >= np - 1) begin
         p_q = 0;
         p_p = (p_p >= 32) ? 0 : p_p + 1;
      end else begin
         p_q++;
      end
      @(negedge clk);
      dat_we = 0; dat_even_en = 0; dat_odd_en = 0;
   endtask

   task automatic set_mode(int b, int c);
      @(negedge clk);
      mode_we = 1; mode_bank = b[0]; mode_chroma = c[0];
      m_pend = b; m_pchr = c;
      @(negedge clk);
      mode_we = 0;
   endtask

   task automatic frame();
      @(negedge clk);
      frame_start = 1;
      m_act = m_pend; m_chr = m_pchr;
      @(negedge clk);
      frame_start = 0;
   endtask

   task automatic rd(int t, int p, int q, string tag);
      int et;
      @(negedge clk);
      rd_en = 1; rd_type = 3'(t); rd_phase = 6'(p); rd_pair = 2'(q);
      if (t > 5 || p > 32) begin
         q_e.push_back(0); q_o.push_back(0);
      end else begin
         et = (m_chr == 0 && (t == 2 || t == 3)) ? t - 2 : t;
         q_e.push_back(me[m_act][et][p][q]);
         q_o.push_back(mo[m_act][et][p][q]);
      end
      q_tag.push_back(tag);
      @(negedge clk);
      rd_en = 0;
   endtask

   // monitor: R9 latency and data comparison
   logic sent = 0;
   always @(posedge clk) sent <= rd_en;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (sent) begin
            int ee, eo;
            string tg;
            n_chk++;
            if (q_e.size() == 0) begin
               n_fail++;
               $display("FAIL R9 read with empty scoreboard actual=%0d expected=%0d", 1, 0);
            end else begin
               ee = q_e.pop_front(); eo = q_o.pop_front(); tg = q_tag.pop_front();
               if (!rd_valid || int'(rd_even) != ee || int'(rd_odd) != eo) begin
                  n_fail++;
                  $display("FAIL %s valid=%0d actual=%0d/%0d expected=%0d/%0d",
                           tg, rd_valid, rd_even, rd_odd, ee, eo);
               end
            end
         end else if (rd_valid) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 rd_valid without request actual=%0d expected=%0d", 1, 0);
         end
      end
   end

   initial begin
      #(8 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      foreach (me[a, b, c, d]) begin
         me[a][b][c][d] = 0;
         mo[a][b][c][d] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk("R10 cur_bank", int'(cur_bank), 0);
      chk("R10 chroma_active", int'(chroma_active), 0);
      chk("R10 rd_valid", int'(rd_valid), 0);

      // R4 pointer walk with 4 taps (2 pairs) into hidden bank 1
      set_taps(4);
      set_addr(1, 0, 0);
      for (int k = 0; k < 6; k++) wr(100 + k * 40 + 1, 2000 + k * 40 + 3, 1, 1);

      // R7 swap request held until frame start
      set_mode(1, 0);
      repeat (2) @(negedge clk);
      chk("R7 no swap before frame", int'(cur_bank), 0);
      frame();
      chk("R7 swap at frame", int'(cur_bank), 1);

      rd(1, 0, 0, "R4 phase0 pair0");
      rd(1, 0, 1, "R4 phase0 pair1");
      rd(1, 1, 0, "R4 phase1 pair0");
      rd(1, 2, 1, "R4 phase2 pair1");

      // R6 write to hidden bank 0 leaves the active bank untouched
      set_addr(1, 0, 0);
      wr('h3FFF, 'h3FFF, 1, 1);
      rd(1, 0, 0, "R6 active bank unchanged");

      // R3 low bits after swapping back
      set_mode(0, 0);
      frame();
      chk("R7 swap back", int'(cur_bank), 0);
      rd(1, 0, 0, "R3 low bits zero");

      // R5 odd taps into hidden bank 1
      set_taps(3);
      set_addr(4, 5, 0);
      for (int k = 0; k < 4; k++) wr(300 + k * 16, 500 + k * 16 + 4, 1, 1);

      // R2 per-half enables
      set_addr(4, 5, 0);
      wr(4000, 4100, 1, 0);
      set_addr(4, 6, 0);
      wr(4200, 4300, 0, 1);

      // R4 wrap from phase 32 with 8 taps
      set_taps(8);
      set_addr(5, 32, 3);
      wr(800, 804, 1, 1);
      wr(900, 904, 1, 1);

      // R8 luma and chroma vertical tables
      set_taps(2);
      set_addr(0, 10, 0);
      wr(1200, 1204, 1, 1);
      set_addr(2, 10, 0);
      wr(1600, 1604, 1, 1);
      // R1 dropped writes to invalid type
      set_addr(6, 0, 0);
      wr(1800, 1804, 1, 1);

      set_mode(1, 0);
      frame();
      rd(4, 5, 0, "R2 even only");
      rd(4, 5, 1, "R5 last odd zero");
      rd(4, 6, 0, "R2 odd only");
      rd(4, 6, 1, "R5 second phase");
      rd(5, 32, 3, "R4 last entry");
      rd(5, 0, 0, "R4 wrapped entry");
      rd(2, 10, 0, "R8 chroma aliases luma");
      rd(6, 0, 0, "R1 invalid type");
      rd(0, 33, 0, "R1 invalid phase");
      rd(3, 10, 0, "R8 chroma horiz aliases luma horiz");

      set_mode(1, 1);
      rd(2, 10, 0, "R8 before frame");
      chk("R8 chroma mode pending", int'(chroma_active), 0);
      frame();
      chk("R8 chroma mode active", int'(chroma_active), 1);
      rd(2, 10, 0, "R8 own chroma table");
      rd(0, 10, 0, "R8 luma unchanged");

      repeat (3) @(negedge clk);
      chk("R9 idle valid low", int'(rd_valid), 0);
      chk("R9 scoreboard drained", q_e.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule